// File: doc/BRIEF.md
# Dummy-Column Frame Synchronizer

The block sits behind the parallel data port of a linear sweep fingerprint sensor. It takes the raw byte stream, one byte per `in_valid` strobe, and finds where each frame begins. Every frame ends its column sequence with an extra column whose first two bytes carry a fixed marker. The marker is a byte with bits 7..5 set, bit 4 free and the low nibble clear, and it appears twice in a row. It recurs exactly once per frame of 1124 bytes (281 columns of four bytes).

When the block is hunting, it waits for two markers spaced exactly one frame apart and then declares lock. When it is locked, it checks for the marker once per frame at the expected slot. A single miss is tolerated, and two misses in a row send it back to hunting. While locked, each byte of a real column is split into its two 4-bit pixels, which are presented in row order together with the column and row numbers. The two status bytes that follow the marker are captured as four nibbles, one of them the temperature-difference code. A one-cycle pulse marks the first pixel pair of each frame.

Top module: `dummy_col_sync`

## Requirements
- R1: After reset, `locked`, `px_valid`, `frame_start` and all four status nibbles are 0.
- R2: A marker byte satisfies `(byte & 8'hEF) == 8'hE0`, with bit 4 ignored. A sync event is two consecutive accepted bytes that are both marker bytes.
- R3: While hunting, `locked` rises one cycle after a sync event whose second byte comes exactly 1124 accepted bytes after the second byte of the previous sync event.
- R4: While hunting, a sync event at any other spacing does not lock. It becomes the new reference for the spacing check, and a missing sync at the expected slot discards the reference.
- R5: While locked, the block checks for a sync event only at the expected slot. One miss keeps lock. A second consecutive miss clears `locked` one cycle after that byte. A hit clears the miss history.
- R6: While unlocked, no pixels are emitted (`px_valid` stays 0).
- R7: Bytes presented with `in_valid` low are ignored. They neither advance the position nor count as marker bytes.
- R8: The four dummy bytes form column 0, which is never emitted. For real column c (1..280) and byte k (0..3) within the column, one cycle after the byte the block shows `px_valid`=1, `px_col`=c and `px_row`=2k+1. `px_odd` carries byte bits 7..4 (row 2k+1) and `px_even` carries byte bits 3..0 (row 2k+2), with bit 3 of each nibble as its MSB.
- R9: `frame_start` is 1 together with the pixel pair of column 1, rows 1–2, and is 0 for every other pair.
- R10: While locked, dummy byte 3 loads `st_ref` (bits 7..4) and `st_temp` (bits 3..0), and dummy byte 4 loads `st_trim` (bits 7..4) and `st_aux` (bits 3..0). The nibbles hold their values while the block is unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_byte | input | 8 | Sensor byte: odd-row nibble in bits 7..4, even-row nibble in bits 3..0 |
| in_valid | input | 1 | `in_byte` is accepted this cycle |
| px_valid | output | 1 | Pixel pair valid |
| px_col | output | 9 | Column index 1..280 |
| px_row | output | 4 | Row of `px_odd` (1,3,5,7); `px_even` is the next row |
| px_odd | output | 4 | Pixel of row `px_row` |
| px_even | output | 4 | Pixel of row `px_row`+1 |
| frame_start | output | 1 | First pixel pair of a frame |
| locked | output | 1 | Frame lock held |
| st_ref | output | 4 | Upper nibble of dummy byte 3 |
| st_temp | output | 4 | Temperature-difference code, lower nibble of dummy byte 3 |
| st_trim | output | 4 | Upper nibble of dummy byte 4 |
| st_aux | output | 4 | Lower nibble of dummy byte 4 |

## Verification
A position counter that is off by one byte shows up at once on the coordinates and nibbles of the next pixel pair. After a lock it also shows up as status nibbles taken from the wrong bytes. A miss history that is not cleared shows up only a frame later, as lock dropped after one bad frame instead of two. A reference that is kept after a wrong spacing shows up as `locked` rising, or failing to rise, a full frame away from where it belongs. The stimulus therefore runs several frames in sequence: a false marker, bit-4 variants, gaps filled with marker-like bytes, and corrupted markers.

// File: rtl/dummy_col_sync.sv
module dummy_col_sync #(
  parameter int COLS = 280,
  parameter int ROWS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] in_byte,
  input  logic       in_valid,
  output logic       px_valid,
  output logic [8:0] px_col,
  output logic [3:0] px_row,
  output logic [3:0] px_odd,
  output logic [3:0] px_even,
  output logic       frame_start,
  output logic       locked,
  output logic [3:0] st_ref,
  output logic [3:0] st_temp,
  output logic [3:0] st_trim,
  output logic [3:0] st_aux
);
  localparam int BPC = ROWS / 2;
  localparam int CW  = $clog2(COLS + 1);
  localparam int SW  = $clog2(BPC);

  logic [CW-1:0] col_q;
  logic [SW-1:0] sub_q;
  logic prev_m, cand_q, miss_q;

  wire cur_m = (in_byte & 8'hEF) == 8'hE0;
  wire hit   = in_valid && cur_m && prev_m;
  wire last_sub = sub_q == SW'(BPC - 1);
  wire [CW-1:0] col_n = last_sub ? ((col_q == CW'(COLS)) ? '0 : col_q + 1'b1) : col_q;
  wire [SW-1:0] sub_n = last_sub ? '0 : sub_q + 1'b1;
  wire at_sync = (col_n == '0) && (sub_n == SW'(1));
  wire emit = in_valid && locked && (col_n != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q <= '0; sub_q <= '0; prev_m <= 1'b0;
      cand_q <= 1'b0; miss_q <= 1'b0; locked <= 1'b0;
    end else if (in_valid) begin
      prev_m <= cur_m;
      if (locked) begin
        col_q <= col_n; sub_q <= sub_n;
        if (at_sync) begin
          if (hit) miss_q <= 1'b0;
          else if (miss_q) begin
            locked <= 1'b0; cand_q <= 1'b0; miss_q <= 1'b0;
          end else miss_q <= 1'b1;
        end
      end else if (hit) begin
        if (cand_q && at_sync) begin
          locked <= 1'b1; cand_q <= 1'b0; miss_q <= 1'b0;
          col_q <= col_n; sub_q <= sub_n;
        end else begin
          cand_q <= 1'b1; col_q <= '0; sub_q <= SW'(1);
        end
      end else begin
        col_q <= col_n; sub_q <= sub_n;
        if (cand_q && at_sync) cand_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      px_valid <= 1'b0; frame_start <= 1'b0;
      px_col <= '0; px_row <= '0; px_odd <= '0; px_even <= '0;
    end else begin
      px_valid    <= emit;
      frame_start <= emit && (col_n == CW'(1)) && (sub_n == '0);
      if (emit) begin
        px_col  <= 9'(col_n);
        px_row  <= 4'({sub_n, 1'b0}) + 4'd1;
        px_odd  <= in_byte[7:4];
        px_even <= in_byte[3:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_ref <= '0; st_temp <= '0; st_trim <= '0; st_aux <= '0;
    end else if (in_valid && locked && col_n == '0) begin
      if (sub_n == SW'(BPC - 2)) begin
        st_ref <= in_byte[7:4]; st_temp <= in_byte[3:0];
      end
      if (sub_n == SW'(BPC - 1)) begin
        st_trim <= in_byte[7:4]; st_aux <= in_byte[3:0];
      end
    end
  end

  p_start_first_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> px_valid && px_col == 9'd1 && px_row == 4'd1);
  p_coord_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid |-> px_col >= 9'd1 && px_col <= 9'(COLS) && px_row[0] && px_row < 4'(ROWS));
  p_no_px_unlocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid |-> $past(locked));
  p_lock_on_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(in_valid));
  p_unlock_on_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(in_valid));
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> !px_valid && $stable(locked) && $stable(st_temp));
endmodule

// File: tb/dummy_col_sync_bench.sv
module dummy_col_sync_bench;
  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [7:0] in_byte = 8'h00;
  logic px_valid, frame_start, locked;
  logic [8:0] px_col;
  logic [3:0] px_row, px_odd, px_even, st_ref, st_temp, st_trim, st_aux;
  int checks = 0, errors = 0;
  logic [21:0] exp_q[$];

  always #2.5 clk = ~clk;

  dummy_col_sync u_dummy_col_sync (
    .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid),
    .px_valid(px_valid), .px_col(px_col), .px_row(px_row), .px_odd(px_odd),
    .px_even(px_even), .frame_start(frame_start), .locked(locked),
    .st_ref(st_ref), .st_temp(st_temp), .st_trim(st_trim), .st_aux(st_aux));

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk); in_byte = b; in_valid = 1;
  endtask

  task automatic gap();
    @(negedge clk); in_byte = 8'hE0; in_valid = 0;
  endtask

  function automatic logic [7:0] db3(input int f); return {4'(f + 2), 4'(f + 7)}; endfunction
  function automatic logic [7:0] db4(input int f); return {4'(f + 9), 4'(15 - f)}; endfunction

  task automatic send_frame(input int f, input bit good, input bit xb, input bit expect_px, input bit gaps);
    logic [7:0] mk;
    mk = good ? {3'b111, xb, 4'h0} : 8'h12;
    put(mk); put(mk); put(db3(f)); put(db4(f));
    for (int c = 1; c <= 280; c++) begin
      for (int k = 0; k < 4; k++) begin
        logic [7:0] b;
        b = {4'(c + k + f), 4'(((c * 3 + k + f) % 15) + 1)};
        if (gaps && ((c + k) % 7 == 0)) gap();
        put(b);
        // R8 R9: expected coordinates, nibble lanes and frame start
        if (expect_px) exp_q.push_back({(c == 1 && k == 0), 9'(c), 4'(2 * k + 1), b[7:4], b[3:0]});
      end
    end
  endtask

  task automatic settle();
    @(negedge clk); in_valid = 0; in_byte = 8'h00;
    @(negedge clk); @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (rst_n && px_valid) begin
        logic [21:0] got;
        got = {frame_start, px_col, px_row, px_odd, px_even};
        if (exp_q.size() == 0) check(0, "R6 unexpected pixel", int'(got), 0);
        else begin
          logic [21:0] e;
          e = exp_q.pop_front();
          check(got == e, "R8 pixel pair", int'(got), int'(e));
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!locked && !px_valid && !frame_start, "R1 reset flags", {locked, px_valid, frame_start}, 0);
    check({st_ref, st_temp, st_trim, st_aux} == 16'h0, "R1 status", {st_ref, st_temp, st_trim, st_aux}, 0);
    rst_n = 1;
    // R4: false marker pair at a wrong spacing inside junk
    for (int i = 0; i < 9; i++) put(8'h55);
    put(8'hE0); put(8'hF0);
    for (int i = 0; i < 17; i++) put(8'h33);
    send_frame(0, 1, 0, 0, 0);
    settle();
    check(!locked, "R4 no lock after wrong spacing", locked, 0);
    check(exp_q.size() == 0, "R6 no pixels while hunting", exp_q.size(), 0);
    // R3: second sync one frame later locks; R2 with bit 4 set
    send_frame(1, 1, 1, 1, 0);
    settle();
    check(locked, "R3 locked after two syncs", locked, 1);
    check({st_ref, st_temp} == db3(1), "R10 dummy byte 3", {st_ref, st_temp}, db3(1));
    check({st_trim, st_aux} == db4(1), "R10 dummy byte 4", {st_trim, st_aux}, db4(1));
    // R7: gaps carrying marker-like bytes with in_valid low
    send_frame(2, 1, 0, 1, 1);
    settle();
    check(locked, "R7 lock kept across gaps", locked, 1);
    // R5: single miss keeps lock
    send_frame(3, 0, 0, 1, 0);
    settle();
    check(locked, "R5 one miss keeps lock", locked, 1);
    send_frame(4, 1, 1, 1, 0);
    settle();
    check({st_ref, st_temp, st_trim, st_aux} == {db3(4), db4(4)}, "R10 status frame 4",
          {st_ref, st_temp, st_trim, st_aux}, {db3(4), db4(4)});
    send_frame(5, 0, 0, 1, 0);
    settle();
    check(locked, "R5 hit cleared miss history", locked, 1);
    send_frame(6, 0, 0, 0, 0);
    settle();
    check(!locked, "R5 two misses drop lock", locked, 0);
    send_frame(7, 1, 0, 0, 0);
    settle();
    check(!locked, "R4 hunt needs two syncs", locked, 0);
    check({st_ref, st_temp, st_trim, st_aux} == {db3(5), db4(5)}, "R10 status held unlocked",
          {st_ref, st_temp, st_trim, st_aux}, {db3(5), db4(5)});
    send_frame(8, 1, 0, 1, 0);
    settle();
    check(locked, "R3 relock", locked, 1);
    check(exp_q.size() == 0, "R8 all pixels seen", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule